// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes written into a small transmit queue into asynchronous serial frames. Its clock is the bit clock, which runs at eight times the baud rate, so every serial bit is held for exactly eight clock cycles. Run-time inputs select the number of data bits, the number of stop bits and the parity mode. They are captured when a frame starts, so they must only change while the block is fully empty. With auto flow control enabled, a new frame starts only while the clear-to-send input is high. A loopback switch sends the serial stream to the receiver-side output instead of the pin.

A frame controller with five enumerated states drives the line. IDLE holds the line high. IDLE goes to START when the queue has data and the flow gate is open. START drives the start bit low and goes to DATA after eight cycles. DATA sends the data bits LSB first. After the last data bit, DATA goes to PARITY if parity is enabled and to STOP if it is not. PARITY goes to STOP after one bit time. STOP holds the line high for one or two bit times. At the end of STOP the controller goes straight back to START when another byte can be launched, and to IDLE when it cannot. Each launch pops one byte from the queue.

Top module: `uartx_top`

## Requirements
- R1: After reset `txd` is 1, `all_empty` is 1, `fifo_full` is 0, and `rx_to_receiver` follows `rx_line_in`.
- R2: A frame begins with a low start bit, followed by 5 + `len_code` data bits sent LSB first (code 0 gives 5 bits and code 3 gives 8). Every bit lasts 8 clock cycles.
- R3: `par_mode` 4 appends an odd-parity bit, 6 appends even parity, 5 appends a constant 1 and 7 appends a constant 0. Codes 0 to 3 send no parity bit. Parity covers only the data bits that are sent.
- R4: Stop bits are high. There are two when `two_stop` is 1 and one when it is 0. Back-to-back frames start 8*(1+data+parity+stop) cycles apart.
- R5: While `flow_en` is 1 and `cts` is 0, no frame starts and queued bytes are kept. When `flow_en` is 0, `cts` has no effect.
- R6: `fifo_full` rises once DEPTH bytes are held. A write while full is dropped, and the queue contents do not change.
- R7: `all_empty` is 1 only when the queue is empty and no frame is being shifted out.
- R8: When `loop_en` is 1, `rx_to_receiver` carries the serial stream and `txd` stays high. When `loop_en` is 0, `rx_to_receiver` equals `rx_line_in`.
- R9: Bytes are sent in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 8x baud |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Byte to queue |
| wr_en | input | 1 | Write strobe |
| fifo_full | output | 1 | Queue cannot accept a byte |
| len_code | input | 2 | Data length code |
| two_stop | input | 1 | Two stop bits when 1 |
| par_mode | input | 3 | Parity mode code |
| flow_en | input | 1 | Gate frame starts on cts |
| cts | input | 1 | Clear to send, high active |
| loop_en | input | 1 | Internal loopback |
| rx_line_in | input | 1 | Serial input from the pin |
| txd | output | 1 | Serial output pin |
| rx_to_receiver | output | 1 | Serial input handed to the receiver |
| all_empty | output | 1 | Queue and shifter both empty |

## Verification
The checker assumes two things about the surroundings. The frame settings stay still while a frame is in flight, and the controller pops the queue only when it holds data. The stimulus changes length, stop and parity settings only after `all_empty` has been seen high and a further bit time has passed. The flow gate and loopback settings are also changed only between frames. Random bytes and settings come from a fixed seed. Directed cases cover a full queue, a blocked clear-to-send, loopback and frame spacing.

// File: rtl/uartx_pkg.sv
package uartx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // parity is present only for codes with the top bit set
    function automatic logic par_enabled(input logic [2:0] mode);
        return mode[2];
    endfunction

    function automatic logic par_value(input logic [7:0] d,
                                       input logic [1:0] len,
                                       input logic [2:0] mode);
        logic [7:0] m;
        logic       x;
        m = d & (8'hFF >> (2'd3 - len));
        x = ^m;
        unique case (mode)
            3'd4:    return ~x;
            3'd5:    return 1'b1;
            3'd6:    return x;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uartx_fifo.sv
module uartx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push;

    assign push  = push_req && !full;
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/uartx_shifter.sv
module uartx_shifter
    import uartx_pkg::*;
#(
    parameter int OVS = 8,
    localparam int SW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    input  logic [1:0] len_code,
    input  logic       two_stop,
    input  logic [2:0] par_mode,
    input  logic       flow_en,
    input  logic       cts,
    output logic       pop,
    output logic       ser_out,
    output logic       busy
);
    tx_state_t state, state_n;
    logic [SW-1:0] sub;
    logic [2:0]    bitn;
    logic          stopn;
    logic [7:0]    shreg;
    logic [2:0]    last_bit;
    logic          par_on;
    logic          stop2;
    logic          pbit;
    logic          launch_ok;
    logic          tick_end;
    logic          stop_last;

    assign launch_ok = !fifo_empty && (!flow_en || cts);
    assign tick_end  = (sub == SW'(OVS - 1));
    assign stop_last = !stop2 || stopn;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (launch_ok) state_n = ST_START;
            ST_START:  if (tick_end) state_n = ST_DATA;
            ST_DATA:   if (tick_end && bitn == last_bit)
                           state_n = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick_end) state_n = ST_STOP;
            ST_STOP:   if (tick_end && stop_last)
                           state_n = launch_ok ? ST_START : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sub      <= '0;
            bitn     <= '0;
            stopn    <= 1'b0;
            shreg    <= '0;
            last_bit <= 3'd7;
            par_on   <= 1'b0;
            stop2    <= 1'b0;
            pbit     <= 1'b0;
        end else begin
            state <= state_n;
            if (pop) begin
                sub      <= '0;
                bitn     <= '0;
                stopn    <= 1'b0;
                shreg    <= fifo_data;
                last_bit <= 3'd4 + {1'b0, len_code};
                par_on   <= par_enabled(par_mode);
                stop2    <= two_stop;
                pbit     <= par_value(fifo_data, len_code, par_mode);
            end else if (state == ST_IDLE) begin
                sub <= '0;
            end else begin
                sub <= tick_end ? '0 : sub + 1'b1;
                if (state == ST_DATA && tick_end) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 1'b1;
                end
                if (state == ST_STOP && tick_end) stopn <= 1'b1;
            end
        end
    end

    always_comb begin
        pop     = 1'b0;
        ser_out = 1'b1;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                pop  = launch_ok;
            end
            ST_START:  ser_out = 1'b0;
            ST_DATA:   ser_out = shreg[0];
            ST_PARITY: ser_out = pbit;
            ST_STOP:   pop = tick_end && stop_last && launch_ok;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/uartx_top.sv
module uartx_top #(
    parameter int DEPTH = 16,
    parameter int OVS   = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    output logic       fifo_full,
    input  logic [1:0] len_code,
    input  logic       two_stop,
    input  logic [2:0] par_mode,
    input  logic       flow_en,
    input  logic       cts,
    input  logic       loop_en,
    input  logic       rx_line_in,
    output logic       txd,
    output logic       rx_to_receiver,
    output logic       all_empty
);
    logic          fifo_empty;
    logic [7:0]    fifo_data;
    logic [CW-1:0] fifo_cnt;
    logic          pop;
    logic          ser;
    logic          busy;

    uartx_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .wdata    (wr_data),
        .pop      (pop),
        .rdata    (fifo_data),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .count    (fifo_cnt)
    );

    uartx_shifter #(.OVS(OVS)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .len_code   (len_code),
        .two_stop   (two_stop),
        .par_mode   (par_mode),
        .flow_en    (flow_en),
        .cts        (cts),
        .pop        (pop),
        .ser_out    (ser),
        .busy       (busy)
    );

    assign txd            = loop_en ? 1'b1 : ser;
    assign rx_to_receiver = loop_en ? ser : rx_line_in;
    assign all_empty      = fifo_empty && !busy;
endmodule

// File: rtl/uartx_chk.sv
module uartx_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_cnt,
    input logic          pop,
    input logic          busy,
    input logic          ser,
    input logic          txd,
    input logic          loop_en,
    input logic          all_empty,
    input logic          flow_en,
    input logic          cts
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && wr_en && !pop |=> fifo_full && $stable(fifo_cnt)); // R6

    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && flow_en && !cts |=> !busy); // R5

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> txd); // R8

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |=> ser); // R7

    AST_START_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser) |=> !ser); // R2
endmodule

bind uartx_top uartx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .fifo_full (fifo_full),
    .fifo_cnt  (fifo_cnt),
    .pop       (pop),
    .busy      (busy),
    .ser       (ser),
    .txd       (txd),
    .loop_en   (loop_en),
    .all_empty (all_empty),
    .flow_en   (flow_en),
    .cts       (cts)
);

// File: tb/uartx_top_tb_top.sv
module uartx_top_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       fifo_full;
    logic [1:0] len_code = 2'd3;
    logic       two_stop = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       flow_en = 1'b0;
    logic       cts = 1'b1;
    logic       loop_en = 1'b0;
    logic       rx_line_in = 1'b1;
    logic       txd;
    logic       rx_to_receiver;
    logic       all_empty;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cyc = 0;
    int last_start = 0;
    int prev_start = 0;
    logic [7:0] exp_q[$];
    logic obs;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign obs = loop_en ? rx_to_receiver : txd;

    uartx_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
        .fifo_full(fifo_full), .len_code(len_code), .two_stop(two_stop),
        .par_mode(par_mode), .flow_en(flow_en), .cts(cts), .loop_en(loop_en),
        .rx_line_in(rx_line_in), .txd(txd), .rx_to_receiver(rx_to_receiver),
        .all_empty(all_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return 5 + int'(len_code);
    endfunction

    function automatic logic exp_par(input logic [7:0] d);
        logic x;
        x = 1'b0;
        for (int i = 0; i < nbits(); i++) x = x ^ d[i];
        case (par_mode)
            3'd4: return !x;
            3'd5: return 1'b1;
            3'd6: return x;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int frame_len();
        return 8 * (1 + nbits() + (par_mode[2] ? 1 : 0) + (two_stop ? 2 : 1));
    endfunction

    task automatic wr_byte(input logic [7:0] b, input bit expect_take);
        @(negedge clk);
        wr_data = b;
        wr_en = 1'b1;
        if (expect_take) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic recv_frame(input string req);
        logic [7:0] got, expv, mask;
        bit stop_ok, quiet_ok;
        int nstop;
        got = '0; stop_ok = 1; quiet_ok = 1;
        @(negedge clk);
        while (obs !== 1'b0) @(negedge clk);
        prev_start = last_start;
        last_start = cyc;
        repeat (3) @(negedge clk);
        chk(obs == 1'b0, "R2 start bit", int'(obs), 0);
        for (int i = 0; i < nbits(); i++) begin
            repeat (8) @(negedge clk);
            got[i] = obs;
            if (loop_en && txd !== 1'b1) quiet_ok = 0;
        end
        expv = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        mask = 8'hFF >> (8 - nbits());
        chk(got == (expv & mask), req, int'(got), int'(expv & mask));
        if (par_mode[2]) begin
            repeat (8) @(negedge clk);
            chk(obs == exp_par(expv), "R3 parity bit", int'(obs), int'(exp_par(expv)));
        end
        nstop = two_stop ? 2 : 1;
        for (int s = 0; s < nstop; s++) begin
            repeat (8) @(negedge clk);
            if (obs !== 1'b1) stop_ok = 0;
            if (loop_en && txd !== 1'b1) quiet_ok = 0;
        end
        chk(stop_ok, "R4 stop bits", int'(stop_ok), 1);
        if (loop_en) chk(quiet_ok, "R8 txd quiet in loopback", int'(quiet_ok), 1);
    endtask

    task automatic settle();
        @(negedge clk);
        while (all_empty !== 1'b1) @(negedge clk);
        repeat (9) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        rx_line_in = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(all_empty == 1'b1, "R1 all_empty", int'(all_empty), 1);
        chk(fifo_full == 1'b0, "R1 fifo_full", int'(fifo_full), 0);
        chk(rx_to_receiver == 1'b0, "R1 rx follows pin", int'(rx_to_receiver), 0);
        rx_line_in = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 frame spacing and R7 busy shifter, 8 bits even parity two stops
        len_code = 2'd3; par_mode = 3'd6; two_stop = 1'b1;
        fork
            begin
                wr_byte(8'hA5, 1);
                wr_byte(8'h3C, 1);
                repeat (20) @(negedge clk);
                chk(all_empty == 1'b0, "R7 not empty while shifting", int'(all_empty), 0);
            end
            begin
                recv_frame("R2 data first");
                recv_frame("R9 data second");
            end
        join
        chk(last_start - prev_start == frame_len(), "R4 frame spacing",
            last_start - prev_start, frame_len());
        settle();
        chk(all_empty == 1'b1, "R7 empty after drain", int'(all_empty), 1);

        // R5 and R6: blocked by cts, fill queue, overflow dropped
        len_code = 2'd3; par_mode = 3'd0; two_stop = 1'b0;
        flow_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++)
            wr_byte(8'h30 + 8'(i), i < DEPTH);
        chk(fifo_full == 1'b1, "R6 full at depth", int'(fifo_full), 1);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R5 no start without cts", int'(txd), 1);
        chk(all_empty == 1'b0, "R5 bytes kept", int'(all_empty), 0);
        cts = 1'b1;
        for (int i = 0; i < DEPTH; i++) recv_frame("R6 R9 queued byte order");
        settle();
        chk(all_empty == 1'b1, "R6 overflow bytes dropped", int'(all_empty), 1);
        chk(fifo_full == 1'b0, "R6 full clears", int'(fifo_full), 0);

        // R5 cts ignored with flow disabled
        flow_en = 1'b0; cts = 1'b0;
        fork
            wr_byte(8'h5A, 1);
            recv_frame("R5 cts ignored");
        join
        cts = 1'b1;
        settle();

        // R8 loopback
        loop_en = 1'b1; rx_line_in = 1'b0;
        len_code = 2'd1; par_mode = 3'd5; two_stop = 1'b1;
        fork
            wr_byte(8'hC7, 1);
            recv_frame("R8 loopback data");
        join
        settle();
        loop_en = 1'b0;
        @(negedge clk);
        chk(rx_to_receiver == 1'b0, "R8 pin passthrough low", int'(rx_to_receiver), 0);
        rx_line_in = 1'b1;
        @(negedge clk);
        chk(rx_to_receiver == 1'b1, "R8 pin passthrough high", int'(rx_to_receiver), 1);

        // random sweep over lengths, parity codes and stop counts: R2 R3 R4
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 3; k++) begin
                len_code = 2'(l);
                par_mode = 3'($urandom % 8);
                two_stop = 1'($urandom % 2);
                flow_en = 1'($urandom % 2);
                fork
                    begin
                        for (int n = 0; n < 4; n++) wr_byte(8'($urandom), 1);
                    end
                    begin
                        for (int n = 0; n < 4; n++) recv_frame("R2 random frame data");
                    end
                join
                chk(last_start - prev_start == frame_len(), "R4 random spacing",
                    last_start - prev_start, frame_len());
                settle();
            end
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule